// File: doc/BRIEF.md
# Grouped Proportional High-Voltage Ramp Controller

This controller produces setpoint codes for a small set of high-voltage channels. Each channel has a target code, a ceiling code and a current limit. Each channel also belongs to one ramping group and one trip group. All channels of a ramping group take their setpoint from one shared fraction. That fraction moves between zero and one at a programmable step per ramp tick. Because of this, the ratio between any two members stays the same for the whole ramp. A sensitive electrode coupled to a stronger one therefore never sees a transient over-potential, and a follower channel simply tracks its leader.

Measured currents arrive as strobed samples. When a channel is above its limit on two consecutive samples, it is marked as tripped. If shutdown is enabled, every channel in the same trip group is forced to zero at once. The ramping groups that hold those channels then ramp down. Further ramp-up requests are refused until a clear is given. A manual kill input shuts down every channel in the same way.

Top module: `hv_ramp_ctrl`

## Requirements
- R1: After reset, every setpoint is 0, and no channel is tripped or killed. No group is busy or full, and the lock is clear.
- R2: A ramp-up request moves every member of the group from its present value to its target code. The group reports busy until it arrives and full once it has arrived (target at or below the ceiling).
- R3: During any ramp, each setpoint equals floor(target × f / 2^FW), with one fraction f common to the group. So a channel whose target is twice another's holds twice its setpoint, or that value plus one.
- R4: The fraction changes only on a ramp tick. A tick comes every TICK_DIV clocks, and each tick moves the fraction by rate_step. A full ramp from 0 therefore takes ceil(2^FW / rate_step) ticks.
- R5: No setpoint ever exceeds its channel's ceiling code. A target above the ceiling settles at the ceiling.
- R6: A ramp-down request brings every member of the group to 0. Ramping groups move independently of one another.
- R7: If ramp-up and ramp-down reach one group in the same cycle, ramp-down wins. A new request reverses a ramp in progress from its current fraction.
- R8: A channel is tripped only when two consecutive valid samples are strictly above its limit. The tripped flag is sticky. A single high sample, or a sample equal to the limit, does not trip the channel.
- R9: With kill_en = 1, a trip kills every channel in the tripping channel's trip group. Their setpoints read 0 from the cycle after the second high sample. Every ramping group that contains a killed channel ramps down.
- R10: With kill_en = 0, a trip only raises the tripped flag. No setpoint changes and nothing is killed or locked.
- R11: Any kill sets the lock. While locked, ramp-up requests are ignored. clr_trip clears the tripped flags, the killed flags, the sample history and the lock, and it takes priority over a kill in the same cycle.
- R12: cmd_kill kills every channel and sets the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_step | input | FW | Fraction step per ramp tick |
| cfg_target | input | N_CH*VW | Per-channel target code |
| cfg_nominal | input | N_CH*VW | Per-channel ceiling code |
| cfg_ilimit | input | N_CH*IW | Per-channel current limit |
| cfg_rgrp | input | N_CH*GW | Ramping group of each channel |
| cfg_tgrp | input | N_CH*GW | Trip group of each channel |
| kill_en | input | 1 | A trip shuts down its trip group |
| cmd_up | input | N_GRP | Ramp-up request per ramping group |
| cmd_down | input | N_GRP | Ramp-down request per ramping group |
| cmd_kill | input | 1 | Kill all channels |
| clr_trip | input | 1 | Clear trips, kills and lock |
| meas_valid | input | 1 | Current samples valid this cycle |
| meas_cur | input | N_CH*IW | Measured current per channel |
| setpoint | output | N_CH*VW | Setpoint code per channel |
| ch_tripped | output | N_CH | Sticky trip flag per channel |
| ch_killed | output | N_CH | Channel forced off |
| grp_busy | output | N_GRP | Ramping group is moving |
| grp_full | output | N_GRP | Group fraction is one |
| locked | output | 1 | Ramp-up refused until clear |

## Verification
A wrong shared fraction shows directly at the setpoints. On the next tick, the fixed ratio between members breaks, or the busy time of a full ramp falls outside its bound of a few ticks. A wrong trip history or kill state shows one clock after the second measurement strobe: a setpoint that should be zero is not, or one that should stay is not. A lock that does not hold shows as a group that goes busy after a refused ramp-up request, within one clock.

// File: rtl/hvr_pkg.sv
package hvr_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } ramp_dir_e;

  // Setpoint from target and shared fraction, clamped to the ceiling.
  function automatic longint unsigned scale_clamp(
    input longint unsigned tgt,
    input longint unsigned ceil_code,
    input longint unsigned frac,
    input int              fw
  );
    longint unsigned prod;
    prod = (tgt * frac) >> fw;
    if (prod > ceil_code) prod = ceil_code;
    return prod;
  endfunction

endpackage

// File: rtl/hvr_tick.sv
module hvr_tick #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/hvr_ramp_grp.sv
module hvr_ramp_grp
  import hvr_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          up,
  input  logic          down,
  input  logic          force_dn,
  input  logic [FW-1:0] rate,
  output logic [FW:0]   frac,
  output logic          busy,
  output logic          full
);
  localparam logic [FW:0] ONE = {1'b1, {FW{1'b0}}};

  ramp_dir_e       dir;
  logic [FW+1:0]   sum;
  logic            reach_top;
  logic            reach_zero;

  assign sum        = {1'b0, frac} + {2'b00, rate};
  assign reach_top  = (sum >= {1'b0, ONE});
  assign reach_zero = (frac <= {1'b0, rate});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir  <= DIR_IDLE;
      frac <= '0;
    end else if (force_dn || down) begin
      dir <= DIR_DOWN;
    end else if (up) begin
      dir <= DIR_UP;
    end else if (tick) begin
      unique case (dir)
        DIR_UP: begin
          if (reach_top) begin
            frac <= ONE;
            dir  <= DIR_IDLE;
          end else begin
            frac <= sum[FW:0];
          end
        end
        DIR_DOWN: begin
          if (reach_zero) begin
            frac <= '0;
            dir  <= DIR_IDLE;
          end else begin
            frac <= frac - {1'b0, rate};
          end
        end
        default: ;
      endcase
    end
  end

  assign busy = (dir != DIR_IDLE);
  assign full = (frac == ONE);
endmodule

// File: rtl/hvr_trip_det.sv
module hvr_trip_det #(
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic [IW-1:0] cur,
  input  logic [IW-1:0] limit,
  input  logic          clr,
  output logic          trip_evt,
  output logic          tripped
);
  logic over;
  logic prev_over;

  assign over     = (cur > limit);
  assign trip_evt = sample && over && prev_over && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_over <= 1'b0;
      tripped   <= 1'b0;
    end else if (clr) begin
      prev_over <= 1'b0;
      tripped   <= 1'b0;
    end else begin
      if (sample)   prev_over <= over;
      if (trip_evt) tripped   <= 1'b1;
    end
  end
endmodule

// File: rtl/hv_ramp_ctrl.sv
module hv_ramp_ctrl
  import hvr_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int N_GRP    = 2,
  parameter int VW       = 12,
  parameter int IW       = 10,
  parameter int FW       = 12,
  parameter int TICK_DIV = 1000,
  parameter int GW       = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FW-1:0]      rate_step,
  input  logic [N_CH*VW-1:0] cfg_target,
  input  logic [N_CH*VW-1:0] cfg_nominal,
  input  logic [N_CH*IW-1:0] cfg_ilimit,
  input  logic [N_CH*GW-1:0] cfg_rgrp,
  input  logic [N_CH*GW-1:0] cfg_tgrp,
  input  logic               kill_en,
  input  logic [N_GRP-1:0]   cmd_up,
  input  logic [N_GRP-1:0]   cmd_down,
  input  logic               cmd_kill,
  input  logic               clr_trip,
  input  logic               meas_valid,
  input  logic [N_CH*IW-1:0] meas_cur,
  output logic [N_CH*VW-1:0] setpoint,
  output logic [N_CH-1:0]    ch_tripped,
  output logic [N_CH-1:0]    ch_killed,
  output logic [N_GRP-1:0]   grp_busy,
  output logic [N_GRP-1:0]   grp_full,
  output logic               locked
);
  localparam int FRW = FW + 1;

  // Named internal events, visible to the bound checker.
  logic                 tick;
  logic [N_CH-1:0]      trip_evt;
  logic [N_CH-1:0]      kill_now;
  logic [N_GRP-1:0]     force_dn;
  logic [N_GRP-1:0]     up_ok;
  logic [N_GRP*FRW-1:0] grp_frac;

  hvr_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_det
    hvr_trip_det #(.IW(IW)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .sample  (meas_valid),
      .cur     (meas_cur[c*IW +: IW]),
      .limit   (cfg_ilimit[c*IW +: IW]),
      .clr     (clr_trip),
      .trip_evt(trip_evt[c]),
      .tripped (ch_tripped[c])
    );
  end

  // A trip kills its whole trip group; a manual kill hits every channel.
  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      kill_now[c] = cmd_kill && !clr_trip;
      for (int d = 0; d < N_CH; d++) begin
        if (kill_en && trip_evt[d] &&
            (cfg_tgrp[d*GW +: GW] == cfg_tgrp[c*GW +: GW]))
          kill_now[c] = 1'b1;
      end
    end
  end

  // Ramping groups holding a killed channel are sent down.
  always_comb begin
    for (int g = 0; g < N_GRP; g++) begin
      force_dn[g] = 1'b0;
      for (int c = 0; c < N_CH; c++) begin
        if (kill_now[c] && (int'(cfg_rgrp[c*GW +: GW]) == g))
          force_dn[g] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_killed <= '0;
      locked    <= 1'b0;
    end else if (clr_trip) begin
      ch_killed <= '0;
      locked    <= 1'b0;
    end else begin
      ch_killed <= ch_killed | kill_now;
      if (|kill_now) locked <= 1'b1;
    end
  end

  assign up_ok = cmd_up & {N_GRP{!locked}};

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    hvr_ramp_grp #(.FW(FW)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .up      (up_ok[g]),
      .down    (cmd_down[g]),
      .force_dn(force_dn[g]),
      .rate    (rate_step),
      .frac    (grp_frac[g*FRW +: FRW]),
      .busy    (grp_busy[g]),
      .full    (grp_full[g])
    );
  end

  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      logic [FRW-1:0] f;
      f = grp_frac[int'(cfg_rgrp[c*GW +: GW])*FRW +: FRW];
      if (ch_killed[c])
        setpoint[c*VW +: VW] = '0;
      else
        setpoint[c*VW +: VW] = VW'(scale_clamp(
          longint'(cfg_target[c*VW +: VW]),
          longint'(cfg_nominal[c*VW +: VW]),
          longint'(f), FW));
    end
  end
endmodule

// File: rtl/hv_ramp_ctrl_chk.sv
module hv_ramp_ctrl_chk #(
  parameter int N_CH  = 4,
  parameter int N_GRP = 2,
  parameter int VW    = 12,
  parameter int FW    = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   kill_en,
  input logic                   cmd_kill,
  input logic                   clr_trip,
  input logic [N_CH*VW-1:0]     cfg_nominal,
  input logic [N_CH*VW-1:0]     setpoint,
  input logic [N_CH-1:0]        ch_tripped,
  input logic [N_CH-1:0]        ch_killed,
  input logic                   locked,
  input logic                   tick,
  input logic [N_GRP*(FW+1)-1:0] grp_frac
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    // R9
    killed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_killed[c] |-> (setpoint[c*VW +: VW] == '0));
    // R5
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      setpoint[c*VW +: VW] <= cfg_nominal[c*VW +: VW]);
  end

  // R4
  frac_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(grp_frac));

  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clr_trip) |=> locked);

  // R11
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_trip |=> (ch_tripped == '0 && ch_killed == '0 && !locked));

  // R12
  manual_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_kill && !clr_trip) |=> (&ch_killed && locked));

  // R10
  no_kill_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_en && !cmd_kill && !locked) |=> !locked);

  // R11
  kill_implies_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_killed != '0) |-> locked);
endmodule

bind hv_ramp_ctrl hv_ramp_ctrl_chk #(
  .N_CH(N_CH), .N_GRP(N_GRP), .VW(VW), .FW(FW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .kill_en    (kill_en),
  .cmd_kill   (cmd_kill),
  .clr_trip   (clr_trip),
  .cfg_nominal(cfg_nominal),
  .setpoint   (setpoint),
  .ch_tripped (ch_tripped),
  .ch_killed  (ch_killed),
  .locked     (locked),
  .tick       (tick),
  .grp_frac   (grp_frac)
);

// File: tb/hv_ramp_ctrl_bench.sv
module hv_ramp_ctrl_bench;
  localparam int N_CH = 4, N_GRP = 2, VW = 12, IW = 10, FW = 12, TD = 4, GW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FW-1:0]      rate_step = FW'(512);
  logic [N_CH*VW-1:0] cfg_target, cfg_nominal;
  logic [N_CH*IW-1:0] cfg_ilimit;
  logic [N_CH*GW-1:0] cfg_rgrp, cfg_tgrp;
  logic               kill_en = 1'b0;
  logic [N_GRP-1:0]   cmd_up = '0, cmd_down = '0;
  logic               cmd_kill = 1'b0, clr_trip = 1'b0, meas_valid = 1'b0;
  logic [N_CH*IW-1:0] meas_cur = '0;
  logic [N_CH*VW-1:0] setpoint;
  logic [N_CH-1:0]    ch_tripped, ch_killed;
  logic [N_GRP-1:0]   grp_busy, grp_full;
  logic               locked;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  hv_ramp_ctrl #(.N_CH(N_CH), .N_GRP(N_GRP), .VW(VW), .IW(IW), .FW(FW),
                 .TICK_DIV(TD)) u_hv_ramp_ctrl (
    .clk(clk), .rst_n(rst_n), .rate_step(rate_step), .cfg_target(cfg_target),
    .cfg_nominal(cfg_nominal), .cfg_ilimit(cfg_ilimit), .cfg_rgrp(cfg_rgrp),
    .cfg_tgrp(cfg_tgrp), .kill_en(kill_en), .cmd_up(cmd_up), .cmd_down(cmd_down),
    .cmd_kill(cmd_kill), .clr_trip(clr_trip), .meas_valid(meas_valid),
    .meas_cur(meas_cur), .setpoint(setpoint), .ch_tripped(ch_tripped),
    .ch_killed(ch_killed), .grp_busy(grp_busy), .grp_full(grp_full), .locked(locked));

  function automatic int sp(input int c);
    return int'(setpoint[c*VW +: VW]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_up(input int g, input logic dn);
    cmd_up[g] = 1'b1; cmd_down[g] = dn;
    @(negedge clk);
    cmd_up = '0; cmd_down = '0;
  endtask

  task automatic pulse_down(input int g);
    cmd_down[g] = 1'b1;
    @(negedge clk);
    cmd_down = '0;
  endtask

  task automatic wait_idle(input int g);
    for (int i = 0; i < 200 && grp_busy[g]; i++) @(negedge clk);
  endtask

  task automatic sample(input int c, input int cur);
    meas_cur = '0;
    meas_cur[c*IW +: IW] = IW'(cur);
    meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
    meas_cur = '0;
  endtask

  task automatic do_clear();
    clr_trip = 1'b1;
    @(negedge clk);
    clr_trip = 1'b0;
  endtask

  task automatic t_reset();
    for (int c = 0; c < N_CH; c++) check("R1 setpoint", sp(c), 0);
    check("R1 tripped", int'(ch_tripped), 0);
    check("R1 killed", int'(ch_killed), 0);
    check("R1 busy", int'(grp_busy), 0);
    check("R1 full", int'(grp_full), 0);
    check("R1 locked", int'(locked), 0);
  endtask

  task automatic t_ramp_up();
    int n = 0, bad_ratio = 0, bad_mono = 0, prev = 0;
    pulse_up(0, 1'b0);
    while (grp_busy[0] && n < 200) begin
      n++;
      if ((sp(1) - 2*sp(0)) < 0 || (sp(1) - 2*sp(0)) > 1) bad_ratio++;
      if ((sp(0) - 2*sp(2)) < 0 || (sp(0) - 2*sp(2)) > 1) bad_ratio++;
      if (sp(0) < prev) bad_mono++;
      prev = sp(0);
      @(negedge clk);
    end
    check("R3 ratio kept", bad_ratio, 0);
    check("R3 monotonic", bad_mono, 0);
    // R4: 8 ticks of 4 clocks; first tick 1..4 clocks after the request
    check("R4 ramp time in range", int'(n >= 29 && n <= 32), 1);
    check("R2 ch0 target", sp(0), 300);
    check("R2 ch1 target", sp(1), 600);
    check("R2 ch2 target", sp(2), 150);
    check("R2 full", int'(grp_full[0]), 1);
    check("R6 other group untouched", sp(3), 0);
  endtask

  task automatic t_clamp();
    pulse_up(1, 1'b0);
    wait_idle(1);
    check("R5 clamp to ceiling", sp(3), 500);
  endtask

  task automatic t_reverse();
    int peak = 0;
    pulse_up(0, 1'b1);
    check("R7 down wins", int'(grp_busy[0] && !grp_full[0]) | int'(sp(0) == 300), 1);
    wait_idle(0);
    check("R7 down wins, ch0 zero", sp(0), 0);
    check("R6 down ch1 zero", sp(1), 0);
    check("R6 group1 kept", sp(3), 500);
    pulse_up(0, 1'b0);
    repeat (12) @(negedge clk);
    peak = sp(0);
    check("R7 mid ramp partial", int'(peak > 0 && peak < 300), 1);
    pulse_down(0);
    wait_idle(0);
    check("R7 reversal to zero", sp(0), 0);
  endtask

  task automatic t_trip_nokill();
    kill_en = 1'b0;
    pulse_up(0, 1'b0);
    wait_idle(0);
    sample(1, 200);
    sample(1, 50);
    check("R8 single high sample", int'(ch_tripped), 0);
    sample(1, 100);
    sample(1, 100);
    check("R8 equal to limit", int'(ch_tripped), 0);
    sample(1, 200);
    sample(1, 201);
    check("R8 two high samples", int'(ch_tripped), 2);
    check("R10 no kill", int'(ch_killed), 0);
    check("R10 setpoint kept", sp(1), 600);
    check("R10 no lock", int'(locked), 0);
  endtask

  task automatic t_kill();
    do_clear();
    check("R11 clear trips", int'(ch_tripped), 0);
    kill_en = 1'b1;
    sample(3, 300);
    sample(3, 300);
    check("R9 killed mask", int'(ch_killed), 4'b1100);
    check("R9 ch2 zero", sp(2), 0);
    check("R9 ch3 zero", sp(3), 0);
    check("R9 ch0 survives", int'(sp(0) > 0), 1);
    check("R9 group0 ramps down", int'(grp_busy[0]), 1);
    check("R11 lock set", int'(locked), 1);
    wait_idle(0);
    wait_idle(1);
    check("R9 ch0 ramped to zero", sp(0), 0);
    pulse_up(1, 1'b0);
    repeat (10) @(negedge clk);
    check("R11 ramp-up refused", int'(grp_busy[1]), 0);
    do_clear();
    check("R11 unlocked", int'(locked), 0);
    check("R11 kills cleared", int'(ch_killed), 0);
    check("R11 ch3 stays zero", sp(3), 0);
    pulse_up(0, 1'b0);
    check("R11 ramp-up accepted", int'(grp_busy[0]), 1);
  endtask

  task automatic t_manual_kill();
    repeat (10) @(negedge clk);
    cmd_kill = 1'b1;
    @(negedge clk);
    cmd_kill = 1'b0;
    check("R12 all killed", int'(ch_killed), 4'b1111);
    check("R12 locked", int'(locked), 1);
    check("R12 ch1 zero", sp(1), 0);
    wait_idle(0);
    do_clear();
  endtask

  initial begin
    for (int c = 0; c < N_CH; c++) begin
      cfg_nominal[c*VW +: VW] = VW'(1000);
      cfg_ilimit[c*IW +: IW]  = IW'(100);
    end
    cfg_target[0*VW +: VW] = VW'(300);
    cfg_target[1*VW +: VW] = VW'(600);
    cfg_target[2*VW +: VW] = VW'(150);
    cfg_target[3*VW +: VW] = VW'(900);
    cfg_nominal[3*VW +: VW] = VW'(500);
    cfg_rgrp = 4'b1000;   // ch0..ch2 in ramp group 0, ch3 in group 1
    cfg_tgrp = 4'b1100;   // ch0,ch1 trip group 0; ch2,ch3 trip group 1
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ramp_up();
    t_clamp();
    t_reverse();
    t_trip_nokill();
    t_kill();
    t_manual_kill();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule